// File: doc/BRIEF.md
# Migrated-Thread Context Slot Manager

This block keeps track of the hardware thread contexts held by one core of a multicore in which threads move to the core that owns the data they touch. It holds a parameterised number of context slots (two by default). Each slot carries an occupancy flag, the thread identifier and the identifier of the thread's native core. Every cycle it names one resident thread for instruction fetch, taking turns among residents. It accepts migrated threads arriving from the network into free slots, and it frees a slot when the pipeline sends a resident thread away on a remote access.

When a thread arrives and every slot is taken, the block does not trade places with the sender. It picks the resident that has waited longest for a fetch turn, sends that thread home to its native core through a dedicated eviction channel, and only then lets the arriving context in. Register file contents and the network itself are handled elsewhere. The manager only decides where contexts live and who runs.

Top module: `ctx_slot_mgr`

## Requirements
- R1: After reset every slot is empty: `grant_valid` is 0, `arr_ready` is 1, `evict_valid` is 0 and `miss_ready` is 0.
- R2: An accepted arrival (`arr_valid` and `arr_ready` both high) is written into the lowest-numbered empty slot. From the next cycle that slot is resident with the arriving thread ID and native core ID.
- R3: Each cycle, if any slot is eligible (resident and not under eviction), exactly one is granted. The search starts one slot past the most recently granted slot and moves upward, wrapping from the top slot to slot 0. `grant_tid` is the granted slot's thread ID.
- R4: Empty slots are skipped by the fetch selection, and `grant_valid` is 0 when no slot is eligible.
- R5: `arr_ready` is high exactly when at least one slot is empty and no eviction is pending.
- R6: An eviction is started when all of these hold: an arrival is offered, every slot is full, no eviction is pending, and no miss departure is accepted in that cycle. The victim is the slot granted for fetch in that cycle. From the next cycle, `evict_valid` is high with the victim's thread ID on `evict_tid` and its native core on `evict_dest`. These stay stable until `evict_ready` is seen.
- R7: While an eviction is pending, the victim is never granted and cannot leave on a miss. Its slot is freed in the cycle the eviction handshake completes. No arrival is accepted before that cycle has passed.
- R8: A miss departure (`miss_valid` with slot `miss_slot`) is accepted (`miss_ready` high) when that slot is resident and is not the pending victim. The slot is empty from the next cycle.
- R9: If a miss departure is accepted in the same cycle that an arrival is offered to a full core, no eviction is started. The arrival is accepted into the freed slot in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_valid | input | 1 | Migrated context offered by the network |
| arr_ready | output | 1 | Arrival can be accepted this cycle |
| arr_tid | input | TID_W | Thread ID of the arriving context |
| arr_origin | input | CORE_W | Native core of the arriving thread |
| miss_valid | input | 1 | Pipeline requests that a resident thread leave |
| miss_slot | input | SLOT_W | Slot of the leaving thread |
| miss_ready | output | 1 | Miss departure accepted this cycle |
| evict_valid | output | 1 | Victim thread is ready to be sent home |
| evict_ready | input | 1 | Network takes the evicted context |
| evict_tid | output | TID_W | Thread ID of the victim |
| evict_dest | output | CORE_W | Native core the victim returns to |
| grant_valid | output | 1 | A thread is granted fetch this cycle |
| grant_slot | output | SLOT_W | Granted slot |
| grant_tid | output | TID_W | Thread ID in the granted slot |

## Verification
The critical overlap is an arrival offered to a full core in the same cycle that the pipeline sends a resident thread away on a miss. The block then has to choose between starting an eviction and simply using the slot that frees up. The bench forces this overlap directly once, and it also produces it often under random stimulus in which arrivals, misses and eviction back-pressure are all frequent. A behavioural reference model predicts, for every cycle, whether an eviction begins, which slot becomes the victim, and when the arrival lands. Any difference in `evict_valid`, `arr_ready` or the later grants is flagged at the cycle where it first appears.

// File: rtl/ctx_slot_pkg.sv
package ctx_slot_pkg;

   typedef enum logic [0:0] {
      SM_IDLE  = 1'b0,
      SM_EVICT = 1'b1
   } sm_state_e;

endpackage

// File: rtl/ctx_slot_rr_pick.sv
module ctx_slot_rr_pick #(
   parameter int N  = 2,
   parameter int SW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  elig,
   input  logic [SW-1:0] last,
   output logic          hit,
   output logic [SW-1:0] pick
);

   generate
      if (N == 2) begin : g_pair
         // two slots: the other one first, then the same one again
         always_comb begin
            hit  = |elig;
            pick = ~last;
            if (!elig[~last]) pick = last;
         end
      end else begin : g_scan
         always_comb begin
            hit  = 1'b0;
            pick = last;
            for (int k = 1; k <= N; k++) begin
               if (!hit && elig[(int'(last) + k) % N]) begin
                  hit  = 1'b1;
                  pick = SW'((int'(last) + k) % N);
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/ctx_slot_free_find.sv
module ctx_slot_free_find #(
   parameter int N  = 2,
   parameter int SW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  occ,
   output logic          any_free,
   output logic [SW-1:0] idx
);

   always_comb begin
      any_free = ~&occ;
      idx      = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (!occ[k]) idx = SW'(k);
      end
   end

endmodule

// File: rtl/ctx_slot_mgr.sv
module ctx_slot_mgr
   import ctx_slot_pkg::*;
#(
   parameter  int NUM_SLOTS = 2,
   parameter  int TID_W     = 8,
   parameter  int CORE_W    = 8,
   localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arr_valid,
   output logic              arr_ready,
   input  logic [TID_W-1:0]  arr_tid,
   input  logic [CORE_W-1:0] arr_origin,
   input  logic              miss_valid,
   input  logic [SLOT_W-1:0] miss_slot,
   output logic              miss_ready,
   output logic              evict_valid,
   input  logic              evict_ready,
   output logic [TID_W-1:0]  evict_tid,
   output logic [CORE_W-1:0] evict_dest,
   output logic              grant_valid,
   output logic [SLOT_W-1:0] grant_slot,
   output logic [TID_W-1:0]  grant_tid
);

   generate
      if (NUM_SLOTS < 2) begin : g_bad_slots
         $error("ctx_slot_mgr: NUM_SLOTS must be at least 2");
      end
      if (TID_W < 1 || CORE_W < 1) begin : g_bad_width
         $error("ctx_slot_mgr: ID widths must be positive");
      end
   endgenerate

   logic [NUM_SLOTS-1:0] valid_q;
   logic [TID_W-1:0]     tid_q    [NUM_SLOTS];
   logic [CORE_W-1:0]    origin_q [NUM_SLOTS];
   logic [SLOT_W-1:0]    last_q;
   logic [SLOT_W-1:0]    victim_q;
   sm_state_e            state_q;

   logic [NUM_SLOTS-1:0] frozen;
   logic [NUM_SLOTS-1:0] eligible;
   logic                 any_free;
   logic [SLOT_W-1:0]    free_idx;
   logic                 arr_fire, miss_fire, evict_fire, start_evict;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_SLOTS; gi++) begin : g_frozen
         assign frozen[gi] = (state_q == SM_EVICT) && (victim_q == SLOT_W'(gi));
      end
   endgenerate

   assign eligible = valid_q & ~frozen;

   ctx_slot_rr_pick #(.N(NUM_SLOTS), .SW(SLOT_W)) i_pick (
      .elig (eligible),
      .last (last_q),
      .hit  (grant_valid),
      .pick (grant_slot)
   );

   ctx_slot_free_find #(.N(NUM_SLOTS), .SW(SLOT_W)) i_free (
      .occ      (valid_q),
      .any_free (any_free),
      .idx      (free_idx)
   );

   assign grant_tid   = tid_q[grant_slot];
   assign arr_ready   = any_free && (state_q == SM_IDLE);
   assign miss_ready  = (int'(miss_slot) < NUM_SLOTS) && eligible[miss_slot];
   assign evict_valid = (state_q == SM_EVICT);
   assign evict_tid   = tid_q[victim_q];
   assign evict_dest  = origin_q[victim_q];

   assign arr_fire    = arr_valid && arr_ready;
   assign miss_fire   = miss_valid && miss_ready;
   assign evict_fire  = evict_valid && evict_ready;
   assign start_evict = (state_q == SM_IDLE) && arr_valid && !any_free && !miss_fire;

   generate
      for (gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot
         logic leave_here, land_here;
         assign leave_here = (miss_fire  && miss_slot == SLOT_W'(gi)) ||
                             (evict_fire && victim_q  == SLOT_W'(gi));
         assign land_here  = arr_fire && (free_idx == SLOT_W'(gi));

         always_ff @(posedge clk) begin
            if (!rst_n)          valid_q[gi] <= 1'b0;
            else if (leave_here) valid_q[gi] <= 1'b0;
            else if (land_here)  valid_q[gi] <= 1'b1;
         end

         always_ff @(posedge clk) begin
            if (land_here) begin
               tid_q[gi]    <= arr_tid;
               origin_q[gi] <= arr_origin;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_q   <= SLOT_W'(NUM_SLOTS - 1);
         victim_q <= '0;
         state_q  <= SM_IDLE;
      end else begin
         if (grant_valid) last_q <= grant_slot;
         case (state_q)
            SM_IDLE: if (start_evict) begin
               victim_q <= grant_slot;
               state_q  <= SM_EVICT;
            end
            SM_EVICT: if (evict_fire) state_q <= SM_IDLE;
            default: state_q <= SM_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ctx_slot_mgr_chk.sv
module ctx_slot_mgr_chk #(
   parameter  int NUM_SLOTS = 2,
   parameter  int TID_W     = 8,
   parameter  int CORE_W    = 8,
   localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 arr_ready,
   input logic                 miss_valid,
   input logic [SLOT_W-1:0]    miss_slot,
   input logic                 miss_ready,
   input logic                 evict_valid,
   input logic                 evict_ready,
   input logic [TID_W-1:0]     evict_tid,
   input logic [CORE_W-1:0]    evict_dest,
   input logic                 grant_valid,
   input logic [SLOT_W-1:0]    grant_slot,
   input logic [NUM_SLOTS-1:0] valid_q,
   input logic [SLOT_W-1:0]    victim_q
);

   a_r4_no_grant_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q == '0) |-> !grant_valid);

   a_r3_grant_is_resident: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> valid_q[grant_slot]);

   a_r5_ready_means_room: assert property (@(posedge clk) disable iff (!rst_n)
      arr_ready |-> (~valid_q != '0));

   a_r6_evict_held: assert property (@(posedge clk) disable iff (!rst_n)
      (evict_valid && !evict_ready) |=> (evict_valid && $stable(evict_tid) && $stable(evict_dest)));

   a_r7_victim_not_granted: assert property (@(posedge clk) disable iff (!rst_n)
      evict_valid |-> !(grant_valid && grant_slot == victim_q));

   a_r7_no_arrival_while_evicting: assert property (@(posedge clk) disable iff (!rst_n)
      evict_valid |-> !arr_ready);

   a_r7_evict_frees_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (evict_valid && evict_ready) |=> !valid_q[$past(victim_q)]);

   a_r8_miss_frees_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && miss_ready) |=> !valid_q[$past(miss_slot)]);

endmodule

bind ctx_slot_mgr ctx_slot_mgr_chk #(
   .NUM_SLOTS (NUM_SLOTS),
   .TID_W     (TID_W),
   .CORE_W    (CORE_W)
) i_ctx_slot_mgr_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .arr_ready   (arr_ready),
   .miss_valid  (miss_valid),
   .miss_slot   (miss_slot),
   .miss_ready  (miss_ready),
   .evict_valid (evict_valid),
   .evict_ready (evict_ready),
   .evict_tid   (evict_tid),
   .evict_dest  (evict_dest),
   .grant_valid (grant_valid),
   .grant_slot  (grant_slot),
   .valid_q     (valid_q),
   .victim_q    (victim_q)
);

// File: tb/test_ctx_slot_mgr.sv
module test_ctx_slot_mgr;

   localparam int NS  = 2;
   localparam int TW  = 8;
   localparam int CW  = 8;
   localparam int SW  = 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          arr_valid = 1'b0;
   logic          arr_ready;
   logic [TW-1:0] arr_tid = '0;
   logic [CW-1:0] arr_origin = '0;
   logic          miss_valid = 1'b0;
   logic [SW-1:0] miss_slot = '0;
   logic          miss_ready;
   logic          evict_valid;
   logic          evict_ready = 1'b0;
   logic [TW-1:0] evict_tid;
   logic [CW-1:0] evict_dest;
   logic          grant_valid;
   logic [SW-1:0] grant_slot;
   logic [TW-1:0] grant_tid;

   always #5 clk = ~clk;

   ctx_slot_mgr #(.NUM_SLOTS(NS), .TID_W(TW), .CORE_W(CW)) i_ctx_slot_mgr (
      .clk, .rst_n,
      .arr_valid, .arr_ready, .arr_tid, .arr_origin,
      .miss_valid, .miss_slot, .miss_ready,
      .evict_valid, .evict_ready, .evict_tid, .evict_dest,
      .grant_valid, .grant_slot, .grant_tid
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   // behavioural reference state
   int m_res [NS];
   int m_tid [NS];
   int m_org [NS];
   int m_last = NS - 1;
   int m_evict = 0;
   int m_victim = 0;
   int m_arr_fire = 0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic step(input bit av, input int tid, input int org,
                       input bit mv, input int ms, input bit er);
      int e_gv, e_gs, e_ar, e_free, e_mr, any_empty, miss_f, ev_f, arr_f, start;
      @(negedge clk);
      arr_valid   = av;
      arr_tid     = TW'(tid);
      arr_origin  = CW'(org);
      miss_valid  = mv;
      miss_slot   = SW'(ms);
      evict_ready = er;
      #1;
      e_gv = 0; e_gs = 0;
      for (int k = 1; k <= NS; k++) begin
         int s;
         s = (m_last + k) % NS;
         if (!e_gv && m_res[s] && !(m_evict && m_victim == s)) begin
            e_gv = 1; e_gs = s;
         end
      end
      any_empty = 0; e_free = 0;
      for (int s = NS - 1; s >= 0; s--) if (!m_res[s]) begin any_empty = 1; e_free = s; end
      e_ar = any_empty && !m_evict;
      e_mr = m_res[ms] && !(m_evict && m_victim == ms);

      chk("R4", "grant_valid", grant_valid, e_gv);
      if (e_gv) begin
         chk("R3", "grant_slot", grant_slot, e_gs);
         chk("R3", "grant_tid", grant_tid, m_tid[e_gs]);
      end
      chk("R5", "arr_ready", arr_ready, e_ar);
      chk("R8", "miss_ready", miss_ready, e_mr);
      chk("R6", "evict_valid", evict_valid, m_evict);
      if (m_evict) begin
         chk("R6", "evict_tid", evict_tid, m_tid[m_victim]);
         chk("R6", "evict_dest", evict_dest, m_org[m_victim]);
      end

      miss_f = mv && e_mr;
      ev_f   = m_evict && er;
      arr_f  = av && e_ar;
      start  = !m_evict && av && !any_empty && !miss_f;
      if (miss_f) m_res[ms] = 0;
      if (ev_f) begin m_res[m_victim] = 0; m_evict = 0; end
      if (arr_f) begin m_res[e_free] = 1; m_tid[e_free] = tid & 255; m_org[e_free] = org & 255; end
      if (start) begin m_evict = 1; m_victim = e_gs; end
      if (e_gv) m_last = e_gs;
      m_arr_fire = arr_f;
   endtask

   task automatic run_random(input int cycles, input int pa, input int pm, input int pe);
      bit pend = 0;
      int ptid = 0, porg = 0;
      for (int c = 0; c < cycles; c++) begin
         if (!pend && $urandom_range(99) < pa) begin
            pend = 1; ptid = $urandom_range(255); porg = $urandom_range(255);
         end
         step(pend, ptid, porg, $urandom_range(99) < pm, $urandom_range(NS - 1),
              $urandom_range(99) < pe);
         if (m_arr_fire != 0) pend = 0;
      end
   endtask

   initial begin
      for (int s = 0; s < NS; s++) begin m_res[s] = 0; m_tid[s] = 0; m_org[s] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: empty core after reset
      chk("R1", "grant_valid", grant_valid, 0);
      chk("R1", "arr_ready", arr_ready, 1);
      chk("R1", "evict_valid", evict_valid, 0);
      chk("R1", "miss_ready", miss_ready, 0);

      // R2: first arrival lands in slot 0 and is granted next cycle
      step(1, 8'h11, 3, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0);
      chk("R2", "slot0 granted", grant_slot, 0);
      chk("R2", "slot0 tid", grant_tid, 8'h11);
      // second arrival fills slot 1
      step(1, 8'h22, 7, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0);
      // arrival to a full core: eviction starts, back-pressure held
      step(1, 8'h33, 9, 0, 0, 0);
      step(1, 8'h33, 9, 0, 0, 0);
      chk("R7", "arr_ready during evict", arr_ready, 0);
      chk("R7", "victim not granted", (grant_valid && grant_slot == SW'(m_victim)) ? 1 : 0, 0);
      step(1, 8'h33, 9, 1, m_victim, 0);
      step(1, 8'h33, 9, 0, 0, 1);
      step(1, 8'h33, 9, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0);
      // R9: miss and arrival to a full core in the same cycle
      step(1, 8'h44, 2, 1, 0, 0);
      chk("R9", "no eviction after collision", evict_valid, 0);
      step(1, 8'h44, 2, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0);
      chk("R9", "evict_valid stays low", evict_valid, 0);
      // R8: both threads leave; empty core skipped by grants (R4)
      step(0, 0, 0, 1, 0, 0);
      step(0, 0, 0, 1, 1, 0);
      step(0, 0, 0, 0, 0, 0);
      chk("R4", "empty core no grant", grant_valid, 0);

      run_random(4000, 40, 15, 50);
      run_random(4000, 90, 5, 20);
      run_random(4000, 60, 40, 80);

      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule